// File: doc/BRIEF.md
# Reversal-Based Barrel Shifter

A purely combinational word shifter that covers logical left, logical right and arithmetic right shifts with one right-shifting network. The network is a chain of logarithmic stages. Each stage moves the word right by a power-of-two distance when its bit of the shift amount is set, and feeds a fill bit into the vacated top positions.

Left shifts do not get a second network. The word is bit-reversed on its way into the network, shifted right with a zero fill, and reversed again on its way out. The result has no register and follows the inputs within the same cycle. An execution unit can use it directly as the shift slice of a datapath.

The data width is a parameter and must be a power of two. The amount width is derived from it. A second parameter picks whether the smallest or the largest stage sits first in the chain. The result is the same either way.

Top module: `revshift_unit`

## Requirements
- R1: With mode 2'b00 (logical left), the result equals the data word shifted left by the amount, with zeros entering at bit 0.
- R2: With mode 2'b01 (logical right), the result equals the data word shifted right by the amount, with zeros entering at the most significant bit.
- R3: With mode 2'b10 (arithmetic right), the result equals the data word shifted right by the amount, with every vacated position taking the original most significant bit.
- R4: An amount of 0 returns the data word unchanged in every mode.
- R5: At the largest amount (WIDTH-1), a logical left shift leaves only the original bit 0, now at the top. A logical right shift leaves only the original top bit, now at bit 0. An arithmetic right shift gives all ones for a negative word and all zeros for a non-negative word.
- R6: Mode 2'b11 is reserved and behaves exactly as a logical right shift.
- R7: For a 32-bit all-ones word shifted by 4, a logical right shift gives 0x0FFFFFFF and an arithmetic right shift gives 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| data_i | input | WIDTH | Word to be shifted |
| amt_i | input | log2(WIDTH) | Shift distance, 0 to WIDTH-1 |
| mode_i | input | 2 | 00 logical left, 01 logical right, 10 arithmetic right, 11 reserved (logical right) |
| res_o | output | WIDTH | Shifted word |

## Verification
The checker watches invariants on every input change:
- a zero amount passes the word through unchanged;
- a left shift by a non-zero amount clears bit 0;
- a logical right shift by a non-zero amount clears the top bit;
- an arithmetic shift keeps the sign bit;
- a logical shift never increases the number of set bits.

These invariants cannot show that the bits land at the exact positions. The bench scenarios show that, by comparing every mode at every amount against the language operators on boundary and random words. The scenarios also cover the reserved mode and the largest-amount corners.

// File: rtl/revshift_pkg.sv
package revshift_pkg;
   typedef enum logic [1:0] {
      SHM_LSL  = 2'b00,
      SHM_LSR  = 2'b01,
      SHM_ASR  = 2'b10,
      SHM_RSVD = 2'b11
   } shm_e;

   function automatic bit is_pow2(input int n);
      return (n >= 2) && ((n & (n - 1)) == 0);
   endfunction
endpackage

// File: rtl/revshift_bitrev.sv
module revshift_bitrev #(
   parameter int W = 32
) (
   input  logic         en_i,
   input  logic [W-1:0] din_i,
   output logic [W-1:0] dout_o
);
   logic [W-1:0] flipped;

   for (genvar g = 0; g < W; g++) begin : g_flip
      assign flipped[g] = din_i[W-1-g];
   end

   assign dout_o = en_i ? flipped : din_i;
endmodule

// File: rtl/revshift_stage.sv
module revshift_stage #(
   parameter int W    = 32,
   parameter int DIST = 1
) (
   input  logic         en_i,
   input  logic         fill_i,
   input  logic [W-1:0] din_i,
   output logic [W-1:0] dout_o
);
   if (DIST < 1 || DIST >= W) begin : g_bad_dist
      $error("revshift_stage: DIST must lie in 1..W-1");
   end

   logic [W-1:0] moved;
   assign moved  = {{DIST{fill_i}}, din_i[W-1:DIST]};
   assign dout_o = en_i ? moved : din_i;
endmodule

// File: rtl/revshift_network.sv
module revshift_network #(
   parameter int W               = 32,
   parameter bit LSB_STAGE_FIRST = 1'b1,
   localparam int AW             = $clog2(W)
) (
   input  logic          fill_i,
   input  logic [AW-1:0] amt_i,
   input  logic [W-1:0]  din_i,
   output logic [W-1:0]  dout_o
);
   logic [W-1:0] chain [AW+1];

   assign chain[0] = din_i;

   for (genvar i = 0; i < AW; i++) begin : g_stage
      localparam int K = LSB_STAGE_FIRST ? i : (AW - 1 - i);
      revshift_stage #(
         .W    (W),
         .DIST (1 << K)
      ) u_stage (
         .en_i   (amt_i[K]),
         .fill_i (fill_i),
         .din_i  (chain[i]),
         .dout_o (chain[i+1])
      );
   end

   assign dout_o = chain[AW];
endmodule

// File: rtl/revshift_unit.sv
module revshift_unit
   import revshift_pkg::*;
#(
   parameter int WIDTH           = 32,
   parameter bit LSB_STAGE_FIRST = 1'b1,
   localparam int AMT_W          = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] data_i,
   input  logic [AMT_W-1:0] amt_i,
   input  logic [1:0]       mode_i,
   output logic [WIDTH-1:0] res_o
);
   if (!is_pow2(WIDTH)) begin : g_bad_width
      $error("revshift_unit: WIDTH must be a power of two, at least 2");
   end

   shm_e         mode;
   logic         go_left;
   logic         fill;
   logic [WIDTH-1:0] net_in;
   logic [WIDTH-1:0] net_out;

   assign mode    = shm_e'(mode_i);
   assign go_left = (mode == SHM_LSL);

   // Zero fill for both logical modes; the left path fills inside the reversed domain.
   always_comb begin
      unique case (mode)
         SHM_ASR: fill = data_i[WIDTH-1];
         default: fill = 1'b0;
      endcase
   end

   revshift_bitrev #(.W(WIDTH)) u_rev_in (
      .en_i   (go_left),
      .din_i  (data_i),
      .dout_o (net_in)
   );

   revshift_network #(
      .W               (WIDTH),
      .LSB_STAGE_FIRST (LSB_STAGE_FIRST)
   ) u_net (
      .fill_i (fill),
      .amt_i  (amt_i),
      .din_i  (net_in),
      .dout_o (net_out)
   );

   revshift_bitrev #(.W(WIDTH)) u_rev_out (
      .en_i   (go_left),
      .din_i  (net_out),
      .dout_o (res_o)
   );
endmodule

// File: rtl/revshift_unit_chk.sv
module revshift_unit_chk #(
   parameter int W  = 32,
   localparam int AW = $clog2(W)
) (
   input logic [W-1:0]  data_i,
   input logic [AW-1:0] amt_i,
   input logic [1:0]    mode_i,
   input logic [W-1:0]  res_o
);
   always_comb begin
      if (amt_i == '0) begin
         a_r4_zero_amt_passes: assert (res_o == data_i)
            else $error("R4: zero amount altered the word");
      end
      if (mode_i == 2'b00 && amt_i != '0) begin
         a_r1_lsl_clears_lsb: assert (res_o[0] == 1'b0)
            else $error("R1: left shift left bit 0 set");
      end
      if ((mode_i == 2'b01 || mode_i == 2'b11) && amt_i != '0) begin
         a_r2_lsr_clears_msb: assert (res_o[W-1] == 1'b0)
            else $error("R2/R6: logical right shift left top bit set");
      end
      if (mode_i == 2'b10) begin
         a_r3_asr_keeps_sign: assert (res_o[W-1] == data_i[W-1])
            else $error("R3: arithmetic shift changed the sign bit");
      end
      if (mode_i != 2'b10) begin
         a_r2_logical_no_new_ones: assert ($countones(res_o) <= $countones(data_i))
            else $error("R1/R2: logical shift created set bits");
      end
   end
endmodule

bind revshift_unit revshift_unit_chk #(.W(WIDTH)) u_chk (
   .data_i (data_i),
   .amt_i  (amt_i),
   .mode_i (mode_i),
   .res_o  (res_o)
);

// File: tb/sim_revshift_unit.sv
`timescale 1ns/1ps
module sim_revshift_unit;
   localparam int W  = 32;
   localparam int AW = 5;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [W-1:0]  data;
   logic [AW-1:0] amt;
   logic [1:0]    mode;
   logic [W-1:0]  res;
   int            n_checks = 0;
   int            n_fail   = 0;
   bit            finished = 1'b0;

   always #4 clk = ~clk;

   revshift_unit #(.WIDTH(W)) u0 (
      .data_i (data),
      .amt_i  (amt),
      .mode_i (mode),
      .res_o  (res)
   );

   task automatic apply(input logic [W-1:0] d, input int a, input logic [1:0] m);
      @(posedge clk);
      data = d;
      amt  = AW'(a);
      mode = m;
      @(negedge clk);
   endtask

   task automatic check(input string req, input logic [W-1:0] exp);
      n_checks++;
      if (res !== exp) begin
         n_fail++;
         $display("FAIL %s data=%h amt=%0d mode=%0d actual=%h expected=%h",
                  req, data, amt, mode, res, exp);
      end
   endtask

   function automatic logic [W-1:0] model(input logic [W-1:0] d, input int a,
                                          input logic [1:0] m);
      case (m)
         2'b00:   return d << a;
         2'b10:   return W'($signed(d) >>> a);
         default: return d >> a;
      endcase
   endfunction

   task automatic t_idle_state();
      apply('0, 0, 2'b00);
      check("R4 idle", '0);
   endtask

   task automatic t_sweep(input logic [W-1:0] d);
      for (int a = 0; a < W; a++) begin
         apply(d, a, 2'b00); check("R1", model(d, a, 2'b00));
         apply(d, a, 2'b01); check("R2", model(d, a, 2'b01));
         apply(d, a, 2'b10); check("R3", model(d, a, 2'b10));
      end
   endtask

   task automatic t_zero_amount();
      for (int m = 0; m < 4; m++) begin
         apply(32'hA5C3_0F96, 0, 2'(m)); check("R4", 32'hA5C3_0F96);
      end
   endtask

   task automatic t_max_amount();
      apply(32'h0000_0001, 31, 2'b00); check("R5 lsl", 32'h8000_0000);
      apply(32'hFFFF_FFFE, 31, 2'b00); check("R5 lsl", 32'h0000_0000);
      apply(32'h8000_0000, 31, 2'b01); check("R5 lsr", 32'h0000_0001);
      apply(32'h8000_0000, 31, 2'b10); check("R5 asr", 32'hFFFF_FFFF);
      apply(32'h7FFF_FFFF, 31, 2'b10); check("R5 asr", 32'h0000_0000);
   endtask

   task automatic t_reserved_mode();
      apply(32'hF000_00F1, 7, 2'b11); check("R6", 32'h01E0_0001);
      apply(32'h8765_4321, 16, 2'b11); check("R6", 32'h0000_8765);
   endtask

   task automatic t_examples();
      apply(32'hFFFF_FFFF, 4, 2'b01); check("R7", 32'h0FFF_FFFF);
      apply(32'hFFFF_FFFF, 4, 2'b10); check("R7", 32'hFFFF_FFFF);
   endtask

   initial begin : watchdog
      #1_000_000;
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin : main
      data = '0;
      amt  = '0;
      mode = '0;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      t_idle_state();
      t_zero_amount();
      t_examples();
      t_max_amount();
      t_reserved_mode();
      t_sweep(32'hFFFF_FFFF);
      t_sweep(32'h8000_0000);
      t_sweep(32'h0000_0001);
      t_sweep(32'h7FFF_FFFF);
      t_sweep(32'hDEAD_BEEF);
      for (int i = 0; i < 4; i++) t_sweep(W'($urandom));
      finished = 1'b1;
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule